// File: doc/BRIEF.md
# Floating-Point and Vector Instruction Trap Decider

This block sits in the issue stage of a processor pipeline. Each cycle it receives a decoded instruction class, the current privilege level and a set of control flags held elsewhere in the core. From these it decides whether the instruction may proceed or must raise one of three faults: device-not-available, invalid-opcode or general-protection. Fault entry, instruction decode and saving floating-point state are handled by other blocks.

The decision covers several cases:
- Lazy floating-point context switching is expressed through a "context switched" flag. A "no float unit" flag sends scalar float work to software emulation and makes the SIMD classes illegal.
- The float wait/synchronise instruction is governed by a "wait monitor" flag.
- Vector SIMD instructions also need the operating system to enable them. A short list of vector-family instructions, such as fences, prefetches, pause, non-temporal integer store, cache-line flush, CRC and population count, is exempt from all of these checks.
- Time-stamp reads and performance-counter reads may be limited to privilege level 0.
- References to the two aliased debug registers can be made illegal.

The decision is computed combinationally and registered once, so the one-hot outcome for an instruction presented in cycle N is visible in cycle N+1.

Top module: `insn_trap_decider`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `outcome` is 4'b0001 (allow), whatever the other inputs are.
- R2: `outcome` is one-hot at every clock edge out of reset. The encoding is bit 0 allow, bit 1 device-not-available, bit 2 invalid-opcode and bit 3 general-protection. It reflects the inputs sampled at the previous rising edge of `clk`, and it does not change between edges.
- R3: For class 0 (scalar float arithmetic), `no_fpu` set gives device-not-available, whatever the value of `ctx_switched`.
- R4: For class 2 (packed-integer SIMD) and class 3 (vector SIMD), `no_fpu` set gives invalid-opcode, even when `ctx_switched` is also set.
- R5: With `no_fpu` clear and `ctx_switched` set, classes 0, 2 and 3 give device-not-available. For class 3 this holds only when `os_vec_ok` is set.
- R6: Class 1 (float wait) gives device-not-available only when both `wait_monitor` and `ctx_switched` are set. Otherwise it is allowed, and `no_fpu` has no effect on it.
- R7: Class 4 (exempt vector-family instruction) is always allowed, whatever the values of `no_fpu`, `ctx_switched` and `os_vec_ok`.
- R8: Class 3 with `os_vec_ok` clear gives invalid-opcode. This takes priority over device-not-available.
- R9: Class 5 (time-stamp read) gives general-protection when `tsc_priv_only` is set and `cpl` is non-zero. In every other case it is allowed.
- R10: Class 6 (performance-counter read) gives general-protection when `pmc_any_level` is clear and `cpl` is non-zero. In every other case it is allowed.
- R11: Class 7 (reference to debug register 4 or 5) gives invalid-opcode when `dbg_strict` is set and is allowed when it is clear, at any privilege level.
- R12: Classes 0, 2 and 3 are allowed when `no_fpu` and `ctx_switched` are clear and, for class 3, `os_vec_ok` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the outcome register updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_class | input | 3 | Instruction class code, 0 to 7 as listed in the requirements |
| no_fpu | input | 1 | No float unit: float work is emulated in software |
| wait_monitor | input | 1 | The float wait instruction observes `ctx_switched` |
| ctx_switched | input | 1 | Set after a task switch: float and SIMD state not yet restored |
| os_vec_ok | input | 1 | The operating system has enabled vector SIMD instructions |
| tsc_priv_only | input | 1 | Time-stamp reads are restricted to privilege level 0 |
| pmc_any_level | input | 1 | Performance-counter reads are allowed at every level |
| dbg_strict | input | 1 | Debug registers 4 and 5 are illegal instead of aliased |
| cpl | input | PRIV_W (2) | Current privilege level, 0 being the most privileged |
| outcome | output | 4 | One-hot decision: allow, device-not-available, invalid-opcode, general-protection |

## Verification
Every decision is due exactly one rising edge after its inputs are applied. The bench therefore drives a vector on a falling edge and compares `outcome` on the next falling edge, when the single register stage has just updated. One scenario also reads `outcome` shortly after driving a new faulting vector, before the edge, to show that the previous decision is still held. The reset check applies a faulting vector while reset is low and waits two falling edges, so any leak past the reset path would be visible.

// File: rtl/trap_pkg.sv
// Package: shared encodings for the instruction trap decider.
// Assumes: class codes come from the decoder as a 3-bit value.
package trap_pkg;

    typedef enum logic [2:0] {
        CLS_FLT       = 3'd0,
        CLS_FSYNC     = 3'd1,
        CLS_PINT      = 3'd2,
        CLS_VEC       = 3'd3,
        CLS_VEC_FREE  = 3'd4,
        CLS_TSC_RD    = 3'd5,
        CLS_PMC_RD    = 3'd6,
        CLS_DBG_ALIAS = 3'd7
    } insn_cls_e;

    localparam int OUT_W    = 4;
    localparam int OB_ALLOW = 0;
    localparam int OB_DEVNA = 1;
    localparam int OB_BADOP = 2;
    localparam int OB_PROT  = 3;

    localparam logic [OUT_W-1:0] OUT_ALLOW = OUT_W'(1) << OB_ALLOW;
    localparam logic [OUT_W-1:0] OUT_DEVNA = OUT_W'(1) << OB_DEVNA;
    localparam logic [OUT_W-1:0] OUT_BADOP = OUT_W'(1) << OB_BADOP;
    localparam logic [OUT_W-1:0] OUT_PROT  = OUT_W'(1) << OB_PROT;

    // Fault requests raised by one decision unit, not yet prioritised.
    typedef struct packed {
        logic badop;
        logic devna;
        logic prot;
    } fault_req_t;

endpackage

// File: rtl/fpu_simd_gate.sv
// Module: fpu_simd_gate
// Decides float and SIMD faults from the emulation, context-switch, wait
// monitor and OS vector-enable flags. Purely combinational.
// Assumes: the exempt vector class is decoded separately by the decoder.
module fpu_simd_gate
    import trap_pkg::*;
(
    input  insn_cls_e  cls,
    input  logic       no_fpu,
    input  logic       wait_monitor,
    input  logic       ctx_switched,
    input  logic       os_vec_ok,
    output fault_req_t req
);

    // Raise the fault requests that apply to the float and SIMD classes.
    always_comb begin
        req = '0;
        unique case (cls)
            CLS_FLT: begin
                req.devna = no_fpu | ctx_switched;
            end
            CLS_FSYNC: begin
                req.devna = wait_monitor & ctx_switched;
            end
            CLS_PINT: begin
                req.badop = no_fpu;
                req.devna = ctx_switched;
            end
            CLS_VEC: begin
                req.badop = no_fpu | ~os_vec_ok;
                req.devna = ctx_switched;
            end
            default: begin
                req = '0;
            end
        endcase
    end

endmodule

// File: rtl/priv_gate.sv
// Module: priv_gate
// Decides privilege-related faults for counter reads and the debug-register
// alias. Purely combinational.
// Assumes: privilege level 0 is the most privileged.
module priv_gate
    import trap_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  insn_cls_e         cls,
    input  logic              tsc_priv_only,
    input  logic              pmc_any_level,
    input  logic              dbg_strict,
    input  logic [PRIV_W-1:0] cpl,
    output fault_req_t        req
);

    logic user_level;

    // Flag any level other than the most privileged one.
    always_comb user_level = (cpl != '0);

    // Raise the fault requests for counter reads and debug aliasing.
    always_comb begin
        req = '0;
        unique case (cls)
            CLS_TSC_RD:    req.prot  = tsc_priv_only & user_level;
            CLS_PMC_RD:    req.prot  = ~pmc_any_level & user_level;
            CLS_DBG_ALIAS: req.badop = dbg_strict;
            default:       req = '0;
        endcase
    end

endmodule

// File: rtl/outcome_merge.sv
// Module: outcome_merge
// Merges fault requests from NUM_SRC units, applies the priority
// invalid-opcode > device-not-available > general-protection > allow,
// and registers the one-hot result.
// Assumes: synchronous active-low reset; the reset value is allow.
module outcome_merge
    import trap_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  fault_req_t [NUM_SRC-1:0] reqs,
    output logic [OUT_W-1:0]         outcome
);

    fault_req_t                merged;
    fault_req_t [NUM_SRC:0]    chain;
    logic       [OUT_W-1:0]    next_out;

    assign chain[0] = '0;

    // OR the requests of all sources together, one stage per source.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_or
        assign chain[s+1] = chain[s] | reqs[s];
    end

    assign merged = chain[NUM_SRC];

    // Pick the highest-priority fault and encode it one-hot.
    always_comb begin
        if (merged.badop)      next_out = OUT_BADOP;
        else if (merged.devna) next_out = OUT_DEVNA;
        else if (merged.prot)  next_out = OUT_PROT;
        else                   next_out = OUT_ALLOW;
    end

    // Hold the decision for the following cycle; reset to allow.
    always_ff @(posedge clk) begin
        if (!rst_n) outcome <= OUT_ALLOW;
        else        outcome <= next_out;
    end

endmodule

// File: rtl/insn_trap_decider.sv
// Module: insn_trap_decider (top)
// Classifies each decoded instruction as allowed or faulting, based on
// control flags and privilege. The result appears one cycle after the inputs.
// Assumes: inputs are stable around the rising edge of clk.
module insn_trap_decider
    import trap_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        insn_class,
    input  logic              no_fpu,
    input  logic              wait_monitor,
    input  logic              ctx_switched,
    input  logic              os_vec_ok,
    input  logic              tsc_priv_only,
    input  logic              pmc_any_level,
    input  logic              dbg_strict,
    input  logic [PRIV_W-1:0] cpl,
    output logic [3:0]        outcome
);

    localparam int NUM_SRC = 2;

    insn_cls_e                 cls;
    fault_req_t [NUM_SRC-1:0]  reqs;

    // Interpret the raw class code as the enumerated class.
    always_comb cls = insn_cls_e'(insn_class);

    fpu_simd_gate u_fpu (
        .cls          (cls),
        .no_fpu       (no_fpu),
        .wait_monitor (wait_monitor),
        .ctx_switched (ctx_switched),
        .os_vec_ok    (os_vec_ok),
        .req          (reqs[0])
    );

    priv_gate #(.PRIV_W(PRIV_W)) u_priv (
        .cls           (cls),
        .tsc_priv_only (tsc_priv_only),
        .pmc_any_level (pmc_any_level),
        .dbg_strict    (dbg_strict),
        .cpl           (cpl),
        .req           (reqs[1])
    );

    outcome_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .reqs    (reqs),
        .outcome (outcome)
    );

endmodule

// File: rtl/insn_trap_decider_chk.sv
// Module: insn_trap_decider_chk
// Port-level properties for insn_trap_decider, attached with bind.
// Assumes: one register stage between the inputs and the outcome.
module insn_trap_decider_chk #(
    parameter int PRIV_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        insn_class,
    input logic              no_fpu,
    input logic              wait_monitor,
    input logic              ctx_switched,
    input logic              os_vec_ok,
    input logic              tsc_priv_only,
    input logic              pmc_any_level,
    input logic              dbg_strict,
    input logic [PRIV_W-1:0] cpl,
    input logic [3:0]        outcome
);

    AST_RESET_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> outcome == 4'b0001) else $error("reset outcome"); // R1

    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(outcome) == 1) else $error("outcome not one-hot"); // R2

    AST_EMU_FLT_DEVNA: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(insn_class == 3'd0 && no_fpu)
        |-> outcome == 4'b0010) else $error("emulated float"); // R3

    AST_EMU_SIMD_BADOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past((insn_class == 3'd2 || insn_class == 3'd3) && no_fpu)
        |-> outcome == 4'b0100) else $error("emulated simd"); // R4

    AST_FSYNC_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(insn_class == 3'd1)
        |-> outcome == ($past(wait_monitor && ctx_switched) ? 4'b0010 : 4'b0001))
        else $error("float wait"); // R6

    AST_EXEMPT_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(insn_class == 3'd4)
        |-> outcome == 4'b0001) else $error("exempt class"); // R7

    AST_VEC_OS_BADOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(insn_class == 3'd3 && !os_vec_ok)
        |-> outcome == 4'b0100) else $error("vector not enabled"); // R8

    AST_DBG_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(insn_class == 3'd7)
        |-> outcome == ($past(dbg_strict) ? 4'b0100 : 4'b0001))
        else $error("debug alias"); // R11

endmodule

bind insn_trap_decider insn_trap_decider_chk #(.PRIV_W(PRIV_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_class    (insn_class),
    .no_fpu        (no_fpu),
    .wait_monitor  (wait_monitor),
    .ctx_switched  (ctx_switched),
    .os_vec_ok     (os_vec_ok),
    .tsc_priv_only (tsc_priv_only),
    .pmc_any_level (pmc_any_level),
    .dbg_strict    (dbg_strict),
    .cpl           (cpl),
    .outcome       (outcome)
);

// File: tb/insn_trap_decider_test.sv
// Directed bench for insn_trap_decider: one task per scenario.
module insn_trap_decider_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] E_ALLOW = 4'b0001;
    localparam logic [3:0] E_DEVNA = 4'b0010;
    localparam logic [3:0] E_BADOP = 4'b0100;
    localparam logic [3:0] E_PROT  = 4'b1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] insn_class = 3'd0;
    logic       no_fpu = 1'b0, wait_monitor = 1'b0, ctx_switched = 1'b0;
    logic       os_vec_ok = 1'b1, tsc_priv_only = 1'b0, pmc_any_level = 1'b0;
    logic       dbg_strict = 1'b0;
    logic [1:0] cpl = 2'd0;
    logic [3:0] outcome;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_trap_decider #(.PRIV_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .insn_class(insn_class),
        .no_fpu(no_fpu), .wait_monitor(wait_monitor),
        .ctx_switched(ctx_switched), .os_vec_ok(os_vec_ok),
        .tsc_priv_only(tsc_priv_only), .pmc_any_level(pmc_any_level),
        .dbg_strict(dbg_strict), .cpl(cpl), .outcome(outcome)
    );

    task automatic check(input string req, input logic [3:0] exp);
        vectors++;
        if (outcome !== exp) begin
            misses++;
            $display("FAIL %s: outcome=%b expected=%b", req, outcome, exp);
        end
    endtask

    // Drive a vector on a falling edge, compare on the next falling edge.
    task automatic apply(input string req, input logic [2:0] c,
                         input logic f, input logic m, input logic t,
                         input logic v, input logic ts, input logic pc,
                         input logic d, input logic [1:0] lvl,
                         input logic [3:0] exp);
        @(negedge clk);
        insn_class = c; no_fpu = f; wait_monitor = m; ctx_switched = t;
        os_vec_ok = v; tsc_priv_only = ts; pmc_any_level = pc;
        dbg_strict = d; cpl = lvl;
        @(negedge clk);
        check(req, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        insn_class = 3'd0; no_fpu = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 in reset", E_ALLOW);
        rst_n = 1'b1;
        #1 check("R1 after release", E_ALLOW);
    endtask

    task automatic t_latency;
        apply("R2 settle", 3'd0, 0, 0, 0, 1, 0, 0, 0, 2'd0, E_ALLOW);
        @(negedge clk);
        insn_class = 3'd0; no_fpu = 1'b1;
        #1 check("R2 held before edge", E_ALLOW);
        @(negedge clk);
        check("R2 updated after edge", E_DEVNA);
    endtask

    task automatic t_emu_float;
        apply("R3 emul", 3'd0, 1, 0, 0, 1, 0, 0, 0, 2'd0, E_DEVNA);
        apply("R3 emul+switched", 3'd0, 1, 1, 1, 1, 0, 0, 0, 2'd3, E_DEVNA);
    endtask

    task automatic t_emu_simd;
        apply("R4 pint emul", 3'd2, 1, 0, 0, 1, 0, 0, 0, 2'd0, E_BADOP);
        apply("R4 vec emul+switched", 3'd3, 1, 0, 1, 1, 0, 0, 0, 2'd0, E_BADOP);
        apply("R4 pint emul+switched", 3'd2, 1, 0, 1, 1, 0, 0, 0, 2'd0, E_BADOP);
    endtask

    task automatic t_switched;
        apply("R5 float", 3'd0, 0, 0, 1, 1, 0, 0, 0, 2'd0, E_DEVNA);
        apply("R5 pint", 3'd2, 0, 0, 1, 1, 0, 0, 0, 2'd0, E_DEVNA);
        apply("R5 vec", 3'd3, 0, 0, 1, 1, 0, 0, 0, 2'd0, E_DEVNA);
    endtask

    task automatic t_fsync;
        apply("R6 monitor+switched", 3'd1, 0, 1, 1, 1, 0, 0, 0, 2'd0, E_DEVNA);
        apply("R6 switched only", 3'd1, 0, 0, 1, 1, 0, 0, 0, 2'd0, E_ALLOW);
        apply("R6 monitor only", 3'd1, 0, 1, 0, 1, 0, 0, 0, 2'd0, E_ALLOW);
        apply("R6 emul ignored", 3'd1, 1, 0, 1, 1, 0, 0, 0, 2'd0, E_ALLOW);
    endtask

    task automatic t_exempt;
        apply("R7 all flags", 3'd4, 1, 1, 1, 0, 0, 0, 0, 2'd3, E_ALLOW);
        apply("R7 os off", 3'd4, 0, 0, 0, 0, 0, 0, 0, 2'd0, E_ALLOW);
    endtask

    task automatic t_os_vec;
        apply("R8 disabled", 3'd3, 0, 0, 0, 0, 0, 0, 0, 2'd0, E_BADOP);
        apply("R8 disabled+switched", 3'd3, 0, 0, 1, 0, 0, 0, 0, 2'd0, E_BADOP);
    endtask

    task automatic t_tsc;
        apply("R9 user restricted", 3'd5, 0, 0, 0, 1, 1, 0, 0, 2'd3, E_PROT);
        apply("R9 level1 restricted", 3'd5, 0, 0, 0, 1, 1, 0, 0, 2'd1, E_PROT);
        apply("R9 kernel restricted", 3'd5, 0, 0, 0, 1, 1, 0, 0, 2'd0, E_ALLOW);
        apply("R9 user open", 3'd5, 0, 0, 0, 1, 0, 0, 0, 2'd3, E_ALLOW);
    endtask

    task automatic t_pmc;
        apply("R10 user closed", 3'd6, 0, 0, 0, 1, 0, 0, 0, 2'd3, E_PROT);
        apply("R10 kernel closed", 3'd6, 0, 0, 0, 1, 0, 0, 0, 2'd0, E_ALLOW);
        apply("R10 user open", 3'd6, 0, 0, 0, 1, 0, 1, 0, 2'd2, E_ALLOW);
    endtask

    task automatic t_dbg;
        apply("R11 strict user", 3'd7, 0, 0, 0, 1, 0, 0, 1, 2'd3, E_BADOP);
        apply("R11 strict kernel", 3'd7, 0, 0, 0, 1, 0, 0, 1, 2'd0, E_BADOP);
        apply("R11 aliased", 3'd7, 0, 0, 0, 1, 0, 0, 0, 2'd3, E_ALLOW);
    endtask

    task automatic t_clear;
        apply("R12 float", 3'd0, 0, 1, 0, 1, 0, 0, 0, 2'd3, E_ALLOW);
        apply("R12 pint", 3'd2, 0, 0, 0, 1, 0, 0, 0, 2'd3, E_ALLOW);
        apply("R12 vec", 3'd3, 0, 0, 0, 1, 1, 0, 1, 2'd0, E_ALLOW);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_emu_float();
        t_emu_simd();
        t_switched();
        t_fsync();
        t_exempt();
        t_os_vec();
        t_tsc();
        t_pmc();
        t_dbg();
        t_clear();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: outcome=%b expected=completion", outcome);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule